// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Logic

This block gathers every interrupt cause of a single UART channel and reports the most urgent one. Each cause is either a level supplied by neighbouring logic, such as the receive error summary, the receive timeout or the FIFO fill counts, or a flag that the block latches from a one-cycle strobe and later clears by a defined rule. A seven-bit enable vector masks the causes. The highest-priority cause that is enabled appears as a 6-bit identification code. The active-low request line asserts whenever at least one enabled cause is pending.

The identification code is combinational, so a host read always sees the current winner. Reads of the identification, modem-status and I/O-state registers reach the block as one-cycle strobes and clear the flags that depend on them. The request output is registered.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset the request output `irq_n` is 1, the code is 6'b000001, and no latched cause is pending.
- R2: The line-status cause (code 6'b000110, enable bit 2) follows the level `rx_err_any` and outranks every other cause.
- R3: The receive timeout (code 6'b001100) and the receive data cause (code 6'b000100) share enable bit 0. When both are pending, the timeout code is reported.
- R4: With `fifo_on`=0 the receive data cause is pending when `rx_count`!=0. With `fifo_on`=1 it is pending when `rx_count` >= `rx_trig`.
- R5: The transmit cause (code 6'b000010, enable bit 1) latches when its condition becomes true. With `fifo_on`=0 the condition is `tx_count`==0. With `fifo_on`=1 the condition is DEPTH-`tx_count` >= `tx_trig`. The latch clears when the condition goes false, or when `iir_rd` is pulsed while 6'b000010 is the reported code.
- R6: A `msr_change` pulse latches the modem cause (code 6'b000000, enable bit 3). A `msr_rd` pulse clears it.
- R7: An `io_change` pulse latches the I/O cause (code 6'b001110, enable bit 4). An `io_rd` pulse clears it.
- R8: An `xoff_det` pulse latches the flow cause (code 6'b010000, enable bit 5). That latch clears only on an `xon_det` pulse. Register reads do not clear it.
- R9: A `special_det` pulse also raises the flow cause. It clears when `iir_rd` is pulsed while 6'b010000 is reported.
- R10: A low-to-high change of `cts_n` or `rts_n` latches the pin cause (code 6'b100000, enable bit 6), which has the lowest priority. High-to-low changes have no effect. The cause clears when `iir_rd` is pulsed while 6'b100000 is reported.
- R11: A cause whose enable bit is 0 affects neither the code nor `irq_n`. With all enables at 0 the code is 6'b000001.
- R12: `irq_n` is low one clock after an enabled cause is pending, and high one clock after none is pending.
- R13: The full priority order, from highest to lowest, is line status, timeout, receive data, transmit, modem, I/O, flow, pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_en | input | 7 | Per-type enable bits |
| fifo_on | input | 1 | FIFO mode selects trigger comparisons |
| rx_err_any | input | 1 | Error present anywhere in receive FIFO |
| rx_timeout | input | 1 | Stale receive data level |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig | input | CW | Receive trigger level |
| tx_count | input | CW | Transmit FIFO fill count |
| tx_trig | input | CW | Transmit free-space trigger level |
| msr_change | input | 1 | Modem input change strobe |
| io_change | input | 1 | General I/O change strobe |
| xoff_det | input | 1 | Stop flow character seen |
| xon_det | input | 1 | Resume flow character seen |
| special_det | input | 1 | Special character matched |
| cts_n | input | 1 | CTS pin level, active low |
| rts_n | input | 1 | RTS pin level, active low |
| iir_rd | input | 1 | Identification register read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| io_rd | input | 1 | I/O state read strobe |
| iir_code | output | 6 | Identification code of winning cause |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The hardest state to reach is one where several latched causes are pending at the same time, each set by its own strobe or pin edge, while the priority and the enable mask are under test. Each of the 256 combinations of eight causes is built from a fresh reset by pulsing the matching strobes and raising the pins together. The bench then sweeps all 128 enable masks with every cause pending. The clear rules are exercised in sequences that try each wrong clearing read before the correct one.

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int CW = 7,
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    irq_en,
  input  logic          fifo_on,
  input  logic          rx_err_any,
  input  logic          rx_timeout,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] tx_trig,
  input  logic          msr_change,
  input  logic          io_change,
  input  logic          xoff_det,
  input  logic          xon_det,
  input  logic          special_det,
  input  logic          cts_n,
  input  logic          rts_n,
  input  logic          iir_rd,
  input  logic          msr_rd,
  input  logic          io_rd,
  output logic [5:0]    iir_code,
  output logic          irq_n
);
  localparam logic [5:0] C_NONE = 6'b000001;
  localparam logic [5:0] C_LS   = 6'b000110;
  localparam logic [5:0] C_TO   = 6'b001100;
  localparam logic [5:0] C_RXD  = 6'b000100;
  localparam logic [5:0] C_TX   = 6'b000010;
  localparam logic [5:0] C_MS   = 6'b000000;
  localparam logic [5:0] C_IO   = 6'b001110;
  localparam logic [5:0] C_FLOW = 6'b010000;
  localparam logic [5:0] C_PIN  = 6'b100000;
  localparam logic [CW:0] DEP   = (CW+1)'(DEPTH);

  logic tx_q, tx_prev, msr_q, io_q, xoff_q, spec_q, pin_q, cts_prev, rts_prev;
  logic rx_ready, tx_cond, tx_set, pin_set, pend;
  logic [CW:0] tx_room;

  assign rx_ready = fifo_on ? (rx_count >= rx_trig) : (rx_count != '0);
  assign tx_room  = DEP - {1'b0, tx_count};
  assign tx_cond  = fifo_on ? (tx_room >= {1'b0, tx_trig}) : (tx_count == '0);
  assign tx_set   = tx_cond & ~tx_prev;
  assign pin_set  = (cts_n & ~cts_prev) | (rts_n & ~rts_prev);

  always_comb begin
    iir_code = C_NONE;
    if (irq_en[6] && pin_q)             iir_code = C_PIN;
    if (irq_en[5] && (xoff_q || spec_q)) iir_code = C_FLOW;
    if (irq_en[4] && io_q)              iir_code = C_IO;
    if (irq_en[3] && msr_q)             iir_code = C_MS;
    if (irq_en[1] && tx_q)              iir_code = C_TX;
    if (irq_en[0] && rx_ready)          iir_code = C_RXD;
    if (irq_en[0] && rx_timeout)        iir_code = C_TO;
    if (irq_en[2] && rx_err_any)        iir_code = C_LS;
  end

  assign pend = (irq_en[2] & rx_err_any) | (irq_en[0] & (rx_timeout | rx_ready)) |
                (irq_en[1] & tx_q) | (irq_en[3] & msr_q) | (irq_en[4] & io_q) |
                (irq_en[5] & (xoff_q | spec_q)) | (irq_en[6] & pin_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= 1'b0; tx_prev <= 1'b0; msr_q <= 1'b0; io_q <= 1'b0;
      xoff_q <= 1'b0; spec_q <= 1'b0; pin_q <= 1'b0;
      cts_prev <= 1'b1; rts_prev <= 1'b1; irq_n <= 1'b1;
    end else begin
      tx_prev  <= tx_cond;
      cts_prev <= cts_n;
      rts_prev <= rts_n;
      irq_n    <= ~pend;
      if (tx_set) tx_q <= 1'b1;
      else if (!tx_cond || (iir_rd && iir_code == C_TX)) tx_q <= 1'b0;
      if (msr_change) msr_q <= 1'b1;
      else if (msr_rd) msr_q <= 1'b0;
      if (io_change) io_q <= 1'b1;
      else if (io_rd) io_q <= 1'b0;
      if (xoff_det) xoff_q <= 1'b1;
      else if (xon_det) xoff_q <= 1'b0;
      if (special_det) spec_q <= 1'b1;
      else if (iir_rd && iir_code == C_FLOW) spec_q <= 1'b0;
      if (pin_set) pin_q <= 1'b1;
      else if (iir_rd && iir_code == C_PIN) pin_q <= 1'b0;
    end
  end
endmodule

module uart_irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] irq_en,
  input logic       rx_err_any,
  input logic       rx_timeout,
  input logic       xon_det,
  input logic       cts_n,
  input logic       rts_n,
  input logic [5:0] iir_code,
  input logic       irq_n,
  input logic       xoff_q,
  input logic       pin_q
);
  logic seen;
  always_ff @(posedge clk) seen <= rst_n;

  assert_irq_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (irq_n == ($past(iir_code) == 6'b000001 && !$past(irq_en[3] && iir_code == 6'b000000))));
  assert_masked_none_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 7'd0) |-> (iir_code == 6'b000001));
  assert_ls_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[2] && rx_err_any) |-> (iir_code == 6'b000110));
  assert_timeout_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en[0] && rx_timeout && !(irq_en[2] && rx_err_any)) |-> (iir_code == 6'b001100));
  assert_xoff_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(xoff_q) && !$past(xon_det)) |-> xoff_q);
  assert_pin_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $rose(pin_q)) |-> $past($rose(cts_n) || $rose(rts_n)));
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rx_err_any(rx_err_any),
  .rx_timeout(rx_timeout), .xon_det(xon_det), .cts_n(cts_n), .rts_n(rts_n),
  .iir_code(iir_code), .irq_n(irq_n), .xoff_q(xoff_q), .pin_q(pin_q)
);

// File: tb/uart_irq_prio_test.sv
`timescale 1ns/1ps
module uart_irq_prio_test;
  localparam int CW = 7;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] irq_en = '1;
  logic fifo_on = 1'b0, rx_err_any = 1'b0, rx_timeout = 1'b0;
  logic [CW-1:0] rx_count = '0, rx_trig = '0, tx_count = 7'd1, tx_trig = '0;
  logic msr_change = 1'b0, io_change = 1'b0, xoff_det = 1'b0, xon_det = 1'b0, special_det = 1'b0;
  logic cts_n = 1'b0, rts_n = 1'b0, iir_rd = 1'b0, msr_rd = 1'b0, io_rd = 1'b0;
  logic [5:0] iir_code;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_prio #(.CW(CW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .fifo_on(fifo_on),
    .rx_err_any(rx_err_any), .rx_timeout(rx_timeout), .rx_count(rx_count),
    .rx_trig(rx_trig), .tx_count(tx_count), .tx_trig(tx_trig),
    .msr_change(msr_change), .io_change(io_change), .xoff_det(xoff_det),
    .xon_det(xon_det), .special_det(special_det), .cts_n(cts_n), .rts_n(rts_n),
    .iir_rd(iir_rd), .msr_rd(msr_rd), .io_rd(io_rd), .iir_code(iir_code), .irq_n(irq_n)
  );

  // pending bits: 0 ls, 1 timeout, 2 rx data, 3 tx, 4 modem, 5 io, 6 flow, 7 pin
  function automatic logic [5:0] expect_code(input logic [7:0] p, input logic [6:0] en);
    logic [7:0] m;
    logic [5:0] codes [8];
    m = p & {en[6], en[5], en[4], en[3], en[1], en[0], en[0], en[2]};
    codes = '{6'b000110, 6'b001100, 6'b000100, 6'b000010, 6'b000000, 6'b001110, 6'b010000, 6'b100000};
    for (int i = 7; i >= 0; i--) if (m[i]) expect_code = codes[i];
    if (m == 8'd0) expect_code = 6'b000001;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act[5:0], exp[5:0]);
    end
  endtask

  task automatic chk_code(input string req, input logic [5:0] e);
    check(iir_code === e, req, int'(iir_code), int'(e));
  endtask

  task automatic chk_irq(input string req, input logic e);
    check(irq_n === e, req, int'(irq_n), int'(e));
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; irq_en = '1; fifo_on = 0; rx_err_any = 0; rx_timeout = 0;
    rx_count = '0; rx_trig = '0; tx_count = 7'd1; tx_trig = '0;
    msr_change = 0; io_change = 0; xoff_det = 0; xon_det = 0; special_det = 0;
    cts_n = 0; rts_n = 0; iir_rd = 0; msr_rd = 0; io_rd = 0;
    tick; tick; rst_n = 1; tick;
  endtask

  task automatic build(input logic [7:0] p);
    do_reset;
    rx_err_any = p[0]; rx_timeout = p[1]; rx_count = p[2] ? 7'd1 : 7'd0;
    tx_count = p[3] ? 7'd0 : 7'd1; msr_change = p[4]; io_change = p[5];
    xoff_det = p[6]; cts_n = p[7];
    tick;
    msr_change = 0; io_change = 0; xoff_det = 0;
    tick;
  endtask

  task automatic pulse_iir; iir_rd = 1; tick; iir_rd = 0; endtask

  initial begin
    #900000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    if (!done) begin $display("  CHECKS %0d ERRORS %0d", checks, errors); $finish; end
  end

  initial begin
    do_reset;
    chk_code("R1 reset code", 6'b000001);
    chk_irq("R1 reset irq", 1'b1);

    // R13 R2 R3: every combination of causes
    for (int p = 0; p < 256; p++) begin
      build(p[7:0]);
      chk_code("R13 priority sweep", expect_code(p[7:0], 7'h7f));
      chk_irq("R12 irq level", (p == 0) ? 1'b1 : 1'b0);
    end

    // R11: enable mask sweep with all causes pending
    build(8'hff);
    for (int e = 0; e < 128; e++) begin
      irq_en = e[6:0];
      #0.1;
      chk_code("R11 mask sweep", expect_code(8'hff, e[6:0]));
      tick;
      chk_irq("R11 mask irq", (e == 0) ? 1'b1 : 1'b0);
    end

    // R4: FIFO receive trigger compare
    do_reset; fifo_on = 1; rx_trig = 7'd16; irq_en = 7'b0000001;
    for (int c = 0; c <= DEPTH; c++) begin
      rx_count = c[CW-1:0]; #0.1;
      chk_code("R4 rx trigger", (c >= 16) ? 6'b000100 : 6'b000001);
    end
    fifo_on = 0; rx_count = 7'd1; #0.1;
    chk_code("R4 rx single char", 6'b000100);

    // R5: FIFO transmit trigger compare, rising latch
    for (int c = 0; c <= DEPTH; c++) begin
      do_reset; fifo_on = 1; tx_trig = 7'd32; irq_en = 7'b0000010; tx_count = 7'd64;
      tick;
      tx_count = c[CW-1:0];
      tick;
      chk_code("R5 tx trigger", ((DEPTH - c) >= 32) ? 6'b000010 : 6'b000001);
    end
    // R5: clear by identification read while reported
    do_reset; tx_count = 0; tick;
    chk_code("R5 tx set", 6'b000010);
    msr_rd = 1; io_rd = 1; tick; msr_rd = 0; io_rd = 0;
    chk_code("R5 tx other reads", 6'b000010);
    pulse_iir;
    chk_code("R5 tx cleared by iir read", 6'b000001);
    // R5: iir read while masked by higher cause does not clear
    do_reset; tx_count = 0; rx_timeout = 1; tick;
    pulse_iir; rx_timeout = 0; #0.1;
    chk_code("R5 tx kept when not reported", 6'b000010);

    // R6 R7
    do_reset; msr_change = 1; io_change = 1; tick; msr_change = 0; io_change = 0;
    chk_code("R6 modem set", 6'b000000);
    pulse_iir;
    chk_code("R6 modem held over iir read", 6'b000000);
    msr_rd = 1; tick; msr_rd = 0;
    chk_code("R7 io after modem clear", 6'b001110);
    io_rd = 1; tick; io_rd = 0;
    chk_code("R7 io cleared", 6'b000001);

    // R8 R9
    do_reset; xoff_det = 1; tick; xoff_det = 0;
    chk_code("R8 xoff set", 6'b010000);
    pulse_iir; msr_rd = 1; io_rd = 1; tick; msr_rd = 0; io_rd = 0;
    chk_code("R8 xoff survives reads", 6'b010000);
    xon_det = 1; tick; xon_det = 0;
    chk_code("R8 xon clears", 6'b000001);
    special_det = 1; tick; special_det = 0;
    chk_code("R9 special set", 6'b010000);
    xon_det = 1; tick; xon_det = 0;
    chk_code("R9 xon does not clear special", 6'b010000);
    pulse_iir;
    chk_code("R9 iir read clears special", 6'b000001);

    // R10
    do_reset; cts_n = 1; rts_n = 1; tick;
    chk_code("R10 rise latched", 6'b100000);
    pulse_iir;
    chk_code("R10 cleared", 6'b000001);
    cts_n = 0; rts_n = 0; tick; tick;
    chk_code("R10 fall ignored", 6'b000001);
    chk_irq("R10 fall ignored irq", 1'b1);
    rts_n = 1; tick;
    chk_code("R10 rts rise", 6'b100000);

    // R12: timing of request
    do_reset; io_change = 1; tick; io_change = 0;
    chk_code("R12 code now", 6'b001110);
    chk_irq("R12 irq not yet", 1'b1);
    tick;
    chk_irq("R12 irq asserted", 1'b0);
    io_rd = 1; tick; io_rd = 0;
    chk_irq("R12 irq still low", 1'b0);
    tick;
    chk_irq("R12 irq released", 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule